// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a strobe that arrives at twice the 32.768 kHz reference frequency into one of fifteen binary-related output rates. A 4-bit rate code picks the rate, and the output frequency is 65536 >> code Hz. Code 1 gives 32.768 kHz and code 15 gives 2 Hz. For each period of the selected rate, the block raises a one-clock periodic-flag pulse and drives a square wave with a 50% duty cycle. The square wave reaches its output pin only while the pin-enable input is high.

A 3-bit divider-control code decodes the reference selection. Codes 6 and 7 hold the divider chain cleared. Every other code lets the chain count strobes. The chain is a binary counter with one stage per rate step, 15 stages in all. The square wave for code r is stage r-1 of that counter. The periodic pulse marks each rising edge of that stage. A host typically programs the rate and reference codes, then releases the hold. It then uses the pulse as an interrupt source and the pin as a clock output.

Top module: `prg_rate_gen`

## Requirements
- R1: While `rst` is high, and at the first clock after it, `sqw_out` and `pf_pulse` are 0 and the divider chain is cleared.
- R2: For `rate_sel` = r in 1..15, while the chain runs and `sqw_en` is 1, `sqw_out` is high for 2^(r-1) strobes and low for 2^(r-1) strobes. Each strobe is a one-cycle high on `ref_tick`, and the output frequency is 65536 >> r Hz.
- R3: `pf_pulse` is high for exactly one clock at each rising edge of the selected square wave, so it fires once per period. It is never high on two consecutive clocks, and it does not depend on `sqw_en`.
- R4: With `rate_sel` = 0, `sqw_out` stays 0 and `pf_pulse` never fires.
- R5: With `sqw_en` = 0, `sqw_out` stays 0 while `pf_pulse` keeps firing at the selected rate.
- R6: A `div_ctl` value of 6 or 7 holds the chain at zero. Strobes are ignored, no pulses occur, and the pin stays 0.
- R7: After `div_ctl` leaves 6/7, the chain restarts from zero. The first `pf_pulse` for rate r comes on strobe number 2^(r-1) after the release.
- R8: `div_ctl` values 0 (4.194 MHz select), 1 (1.049 MHz select), 2 (32.768 kHz select) and 3..5 (test codes) all let the chain count strobes. Moving between these codes neither clears nor pauses the chain.
- R9: A strobe sampled at clock edge E changes `sqw_out` and `pf_pulse` at edge E+1, not at E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe at twice the reference frequency |
| rate_sel | input | 4 | Rate code: 0 off, r gives 65536 >> r Hz |
| div_ctl | input | 3 | Reference select; 6 and 7 hold the chain in reset |
| sqw_en | input | 1 | Gates the square wave onto the pin |
| pf_pulse | output | 1 | One-clock pulse per period of the selected rate |
| sqw_out | output | 1 | Gated 50% square wave |

## Verification
A chain that drops or doubles a strobe moves the pin edge and the pulse by a whole strobe. At slow rates the fault surfaces only at the next transition of the selected stage, which can be up to 2^(r-1) strobes later. The bench therefore compares pin and pulse after every strobe against its own strobe count, and it also checks the position of the first pulse after a hold is released. An edge detector whose history register is stale shows up at once as a doubled or missing pulse. A wrong hold decode shows up as pulses during a hold, or as a chain that does not restart at zero after the release.

// File: rtl/prg_pkg.sv
package prg_pkg;

    localparam int DIV_W = 3;

    typedef enum logic [2:0] {
        MODE_FAST4M  = 3'd0,
        MODE_FAST1M  = 3'd1,
        MODE_SLOW32K = 3'd2,
        MODE_TEST    = 3'd3,
        MODE_HOLD    = 3'd4
    } ref_mode_e;

    typedef struct packed {
        logic sq;
        logic pulse;
    } rate_out_t;

    function automatic ref_mode_e decode_div(input logic [DIV_W-1:0] code);
        ref_mode_e m;
        case (code)
            3'd0:    m = MODE_FAST4M;
            3'd1:    m = MODE_FAST1M;
            3'd2:    m = MODE_SLOW32K;
            3'd3,
            3'd4,
            3'd5:    m = MODE_TEST;
            default: m = MODE_HOLD;
        endcase
        return m;
    endfunction

    function automatic logic mode_holds(input ref_mode_e m);
        return m == MODE_HOLD;
    endfunction

endpackage

// File: rtl/prg_div_decode.sv
module prg_div_decode
    import prg_pkg::*;
(
    input  logic [DIV_W-1:0] div_ctl,
    output ref_mode_e        mode,
    output logic             hold
);
    always_comb begin
        mode = decode_div(div_ctl);
        hold = mode_holds(mode);
    end
endmodule

// File: rtl/prg_div_chain.sv
module prg_div_chain #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold,
    output logic [STAGES-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/prg_tap_sel.sv
module prg_tap_sel #(
    parameter int SEL_W  = 4,
    parameter int STAGES = 15
) (
    input  logic [STAGES-1:0] cnt,
    input  logic [SEL_W-1:0]  rate_sel,
    output logic              tap
);
    localparam int NTAP = 1 << SEL_W;

    logic [NTAP-1:0] taps;

    assign taps[0] = 1'b0;

    for (genvar i = 1; i < NTAP; i++) begin : g_tap
        if (i <= STAGES) begin : g_live
            assign taps[i] = cnt[i-1];
        end else begin : g_dead
            assign taps[i] = 1'b0;
        end
    end

    assign tap = taps[rate_sel];
endmodule

// File: rtl/prg_edge_out.sv
module prg_edge_out
    import prg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tap,
    input  logic      pin_en,
    output rate_out_t outs
);
    logic tap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outs  <= '0;
            tap_q <= 1'b0;
        end else begin
            outs.sq    <= tap & pin_en;
            outs.pulse <= tap & ~tap_q;
            tap_q      <= tap;
        end
    end
endmodule

// File: rtl/prg_rate_gen.sv
module prg_rate_gen
    import prg_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic [2:0]       div_ctl,
    input  logic             sqw_en,
    output logic             pf_pulse,
    output logic             sqw_out
);
    localparam int STAGES = (1 << SEL_W) - 1;

    ref_mode_e         ref_mode;
    logic              chain_hold;
    logic [STAGES-1:0] div_cnt;
    logic              sel_tap;
    rate_out_t         outs;

    prg_div_decode u_decode (
        .div_ctl (div_ctl),
        .mode    (ref_mode),
        .hold    (chain_hold)
    );

    prg_div_chain #(.STAGES(STAGES)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .tick (ref_tick),
        .hold (chain_hold),
        .cnt  (div_cnt)
    );

    prg_tap_sel #(.SEL_W(SEL_W), .STAGES(STAGES)) u_tap (
        .cnt      (div_cnt),
        .rate_sel (rate_sel),
        .tap      (sel_tap)
    );

    prg_edge_out u_out (
        .clk    (clk),
        .rst    (rst),
        .tap    (sel_tap),
        .pin_en (sqw_en),
        .outs   (outs)
    );

    assign pf_pulse = outs.pulse;
    assign sqw_out  = outs.sq;
endmodule

// File: rtl/prg_rate_gen_chk.sv
module prg_rate_gen_chk #(
    parameter int SEL_W  = 4,
    parameter int STAGES = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_tick,
    input logic [SEL_W-1:0]  rate_sel,
    input logic              sqw_en,
    input logic              pf_pulse,
    input logic              sqw_out,
    input logic              hold,
    input logic [STAGES-1:0] cnt
);
    // R1: first clock after reset shows a cleared chain and quiet outputs
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (cnt == '0 && !pf_pulse && !sqw_out));

    // R2 / R8: each accepted strobe advances the chain by one
    p_chain_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ref_tick) && !$past(hold)) |-> cnt == $past(cnt) + 1'b1);

    // R3: pulse lasts one clock
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        pf_pulse |=> !pf_pulse);

    // R3: with the pin enabled, a pulse coincides with a rising pin
    p_pulse_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pf_pulse && $past(sqw_en) && $past(sqw_en, 2))
            |-> (sqw_out && !$past(sqw_out)));

    // R4: rate code zero silences both outputs
    p_rate_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rate_sel) == '0) |-> (!sqw_out && !pf_pulse));

    // R5: disabled pin stays low
    p_pin_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(sqw_en) |-> !sqw_out);

    // R6: hold keeps the chain at zero
    p_hold_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hold)) |-> cnt == '0);
endmodule

bind prg_rate_gen prg_rate_gen_chk #(.SEL_W(SEL_W), .STAGES(STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .rate_sel (rate_sel),
    .sqw_en   (sqw_en),
    .pf_pulse (pf_pulse),
    .sqw_out  (sqw_out),
    .hold     (chain_hold),
    .cnt      (div_cnt)
);

// File: tb/prg_rate_gen_bench.sv
module prg_rate_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic [2:0] div_ctl = 3'd2;
    logic       sqw_en = 1'b0;
    logic       pf_pulse;
    logic       sqw_out;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    logic [15:0] m_cnt = '0;
    logic        m_tap_prev = 1'b0;
    bit          m_hold = 1'b0;
    int          pulse_count = 0;
    int          first_rise = -1;
    int          tick_idx = 0;

    prg_rate_gen u_prg_rate_gen (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .rate_sel (rate_sel),
        .div_ctl  (div_ctl),
        .sqw_en   (sqw_en),
        .pf_pulse (pf_pulse),
        .sqw_out  (sqw_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_tap();
        if (rate_sel == 4'd0) return 1'b0;
        return m_cnt[rate_sel - 4'd1];
    endfunction

    task automatic do_tick();
        logic old_pin, t, p;
        old_pin = exp_tap() && sqw_en;
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) ref_tick = 1'b0;
        chk("R9", "pin one edge after strobe", int'(sqw_out), int'(old_pin));
        chk("R3", "pulse idle between strobes", int'(pf_pulse), 0);
        if (!m_hold) m_cnt = m_cnt + 16'd1;
        tick_idx++;
        t = exp_tap();
        p = t && !m_tap_prev;
        m_tap_prev = t;
        @(negedge clk);
        chk("R2", "pin level", int'(sqw_out), int'(t && sqw_en));
        chk("R3", "pulse on rise", int'(pf_pulse), int'(p));
        if (pf_pulse) begin
            pulse_count++;
            if (first_rise < 0) first_rise = tick_idx;
        end
    endtask

    task automatic apply(input logic [2:0] div, input logic [3:0] rate, input logic en);
        @(negedge clk);
        div_ctl  = div;
        rate_sel = rate;
        sqw_en   = en;
        @(negedge clk);
        @(negedge clk);
        m_hold = (div >= 3'd6);
        if (m_hold) m_cnt = '0;
        m_tap_prev = exp_tap();
    endtask

    task automatic start_rate(input logic [3:0] rate, input logic en);
        apply(3'd6, rate, en);
        apply(3'd2, rate, en);
        pulse_count = 0;
        first_rise  = -1;
        tick_idx    = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "pin in reset", int'(sqw_out), 0);
        chk("R1", "pulse in reset", int'(pf_pulse), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "pin after reset", int'(sqw_out), 0);
        chk("R1", "pulse after reset", int'(pf_pulse), 0);
        m_cnt = '0;
        m_tap_prev = 1'b0;
    endtask

    task automatic t_rate(input int r, input int n);
        int half, expn;
        half = 1 << (r - 1);
        start_rate(4'(r), 1'b1);
        repeat (n) do_tick();
        expn = 0;
        for (int k = half; k <= n; k += (1 << r)) expn++;
        chk("R2", $sformatf("pulse count rate %0d", r), pulse_count, expn);
        chk("R7", $sformatf("first rise rate %0d", r), first_rise, half);
    endtask

    task automatic t_rate_zero();
        start_rate(4'd0, 1'b1);
        repeat (64) do_tick();
        chk("R4", "pulses at rate 0", pulse_count, 0);
        chk("R4", "pin at rate 0", int'(sqw_out), 0);
    endtask

    task automatic t_pin_off();
        start_rate(4'd4, 1'b0);
        repeat (64) do_tick();
        chk("R5", "pulses with pin off", pulse_count, 4);
        chk("R5", "pin off", int'(sqw_out), 0);
    endtask

    task automatic t_hold();
        start_rate(4'd1, 1'b1);
        repeat (5) do_tick();
        apply(3'd7, 4'd1, 1'b1);
        pulse_count = 0;
        repeat (20) do_tick();
        chk("R6", "pulses during hold", pulse_count, 0);
        chk("R6", "pin during hold", int'(sqw_out), 0);
        apply(3'd6, 4'd3, 1'b1);
        repeat (6) do_tick();
        chk("R6", "pulses during hold code 6", pulse_count, 0);
        apply(3'd2, 4'd3, 1'b1);
        pulse_count = 0;
        first_rise  = -1;
        tick_idx    = 0;
        repeat (8) do_tick();
        chk("R7", "first rise after release", first_rise, 4);
        chk("R7", "pulses after release", pulse_count, 1);
    endtask

    task automatic t_codes();
        logic [2:0] codes [5] = '{3'd0, 3'd1, 3'd3, 3'd4, 3'd5};
        start_rate(4'd2, 1'b1);
        for (int c = 0; c < 5; c++) begin
            apply(codes[c], 4'd2, 1'b1);
            repeat (8) do_tick();
        end
        chk("R8", "pulses across running codes", pulse_count, 10);
    endtask

    initial begin
        t_reset();
        t_rate(1, 64);
        t_rate(2, 64);
        t_rate(3, 64);
        t_rate(5, 64);
        t_rate(8, 300);
        t_rate_zero();
        t_pin_off();
        t_hold();
        t_codes();
        t_rate(15, 32768);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule